// File: doc/BRIEF.md
# Command Stream Method Decoder

This block turns a stream of 32-bit command words into single method writes. A word that arrives while no data is pending is a header. The header sets a method address, a subchannel, a count of data words and a rule for stepping the address. The words that follow are the arguments of successive methods. An immediate header carries its own small argument and produces exactly one method.

Each method goes to one of three output ports, chosen by its address. Low addresses go to a class-register port as a byte offset. The middle range goes to an engine port tagged with its subchannel. The top range goes to a macro port as a macro index, a start/push flag and an execute strobe.

The word input uses a valid/ready handshake. A word is taken only in the cycle its method is accepted by the selected port, so nothing is lost when a port stalls. Outputs are combinational from the current word and the decoder state, with no extra pipeline register.

Top module: `cmd_method_decoder`

## Requirements
- R1: After reset, the first word is decoded as a header. Header bits [31:29] are the kind, [28:16] the count or immediate value, [15:13] the subchannel and [11:0] the method address. In the idle state with no word offered, `word_ready_o` is 1 and no port is valid.
- R2: Kind 1 (incrementing) with count N emits N methods at addresses A, A+1, ..., A+N-1. The data words are used as arguments in arrival order.
- R3: Kind 3 (non-incrementing) emits all N methods at address A.
- R4: Kind 5 (increment-once) emits the first method at A and every later method at A+1.
- R5: Kind 4 (immediate) emits one method at once. Its argument is bits [28:16] zero-extended. The next word is again decoded as a header.
- R6: Header kinds 0, 2, 6 and 7, and headers of kind 1, 3 or 5 with a count of 0, are accepted without emitting anything. The word after such a header is still decoded as a header.
- R7: A method with address below 0x60 goes to the class port with `cls_offset_o` = address × 4.
- R8: A method with address from 0x60 to 0xDFF goes to the engine port with its address and subchannel.
- R9: A method with address 0xE00 or above goes to the macro port. `mac_index_o` is (address >> 1) & 0x7F, and `mac_push_o` is address bit 0 (1 = push an argument, 0 = start with the first argument).
- R10: `mac_exec_o` is 1 exactly on a macro method that is the last data word of its header, or that comes from an immediate header.
- R11: When a method is pending and its selected port's ready is low, `word_ready_o` is low and the word is held. Headers that emit nothing are always accepted, whatever the ports' readies.
- R12: At most one of the three port valids is high in any cycle. None is high while no word is offered.
- R13: Reset, including reset in the middle of a data run, clears the remaining count, so the next word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Command word |
| word_valid_i | input | 1 | Command word valid |
| word_ready_o | output | 1 | Command word accepted this cycle |
| cls_valid_o | output | 1 | Class-register method valid |
| cls_ready_i | input | 1 | Class port can accept |
| cls_offset_o | output | 14 | Class register byte offset |
| cls_data_o | output | 32 | Class method argument |
| eng_valid_o | output | 1 | Engine method valid |
| eng_ready_i | input | 1 | Engine port can accept |
| eng_subch_o | output | 3 | Engine subchannel |
| eng_method_o | output | 12 | Engine method address |
| eng_data_o | output | 32 | Engine method argument |
| mac_valid_o | output | 1 | Macro method valid |
| mac_ready_i | input | 1 | Macro port can accept |
| mac_index_o | output | 7 | Macro slot index |
| mac_push_o | output | 1 | 1 = argument push, 0 = start |
| mac_exec_o | output | 1 | Execute strobe for the indexed macro |
| mac_data_o | output | 32 | Macro argument |

## Verification
The bench targets the range edges 0x5F/0x60 and 0xDFF/0xE00. It runs a single incrementing header across each edge, so an off-by-one limit would send a method to the wrong port or with the wrong offset.

Increment-once runs longer than two words, and non-incrementing runs, catch a stepper that keeps counting or never steps. An immediate header followed directly by another header catches a decoder that consumes one word too many. Ignored kinds and zero-count headers, each followed by a real header, catch state that is wrongly loaded.

A stalled engine port must hold the word without losing or duplicating it. A reset in the middle of a run must not let a stale count turn the next header into data. Execute strobes are compared on every macro method, so a strobe on a non-final word or a missing strobe on an immediate shows up as a mismatch.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int CNT_W     = 13;
  localparam int SUBCH_W   = 3;
  localparam int KIND_W    = 3;
  localparam int MAC_IDX_W = 7;

  localparam int KIND_LSB  = 29;
  localparam int CNT_LSB   = 16;
  localparam int SUBCH_LSB = 13;

  localparam logic [KIND_W-1:0] KIND_INC    = 3'd1;
  localparam logic [KIND_W-1:0] KIND_HOLD   = 3'd3;
  localparam logic [KIND_W-1:0] KIND_IMM    = 3'd4;
  localparam logic [KIND_W-1:0] KIND_ONCE   = 3'd5;

  typedef enum logic [1:0] {
    STEP_INC  = 2'd0,
    STEP_HOLD = 2'd1,
    STEP_ONCE = 2'd2
  } step_mode_e;

  typedef enum logic [1:0] {
    PORT_CLS = 2'd0,
    PORT_ENG = 2'd1,
    PORT_MAC = 2'd2
  } port_e;

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [SUBCH_W-1:0] subch;
    logic [WORD_W-1:0]  data;
    logic               last;
  } method_t;
endpackage

// File: rtl/cmd_hdr_parse.sv
module cmd_hdr_parse
  import cmd_dec_pkg::*;
(
  input  logic [WORD_W-1:0]  word_i,
  output logic               is_run_o,
  output logic               is_imm_o,
  output step_mode_e         mode_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [SUBCH_W-1:0] subch_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [WORD_W-1:0]  imm_o
);
  logic [KIND_W-1:0] kind;

  assign kind    = word_i[KIND_LSB +: KIND_W];
  assign cnt_o   = word_i[CNT_LSB +: CNT_W];
  assign subch_o = word_i[SUBCH_LSB +: SUBCH_W];
  assign addr_o  = word_i[ADDR_W-1:0];
  assign imm_o   = {{(WORD_W-CNT_W){1'b0}}, cnt_o};

  always_comb begin
    is_run_o = 1'b0;
    is_imm_o = 1'b0;
    mode_o   = STEP_INC;
    unique case (kind)
      KIND_INC:  begin is_run_o = (cnt_o != '0); mode_o = STEP_INC;  end
      KIND_HOLD: begin is_run_o = (cnt_o != '0); mode_o = STEP_HOLD; end
      KIND_ONCE: begin is_run_o = (cnt_o != '0); mode_o = STEP_ONCE; end
      KIND_IMM:  is_imm_o = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/cmd_seq_state.sv
module cmd_seq_state
  import cmd_dec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [SUBCH_W-1:0] subch_i,
  input  step_mode_e         mode_i,
  output logic               busy_o,
  output logic               last_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [SUBCH_W-1:0] subch_o
);
  logic [CNT_W-1:0] cnt_q;
  step_mode_e       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      addr_o  <= '0;
      subch_o <= '0;
      mode_q  <= STEP_INC;
    end else if (load_i) begin
      cnt_q   <= cnt_i;
      addr_o  <= addr_i;
      subch_o <= subch_i;
      mode_q  <= mode_i;
    end else if (step_i) begin
      cnt_q <= cnt_q - 1'b1;
      unique case (mode_q)
        STEP_INC:  addr_o <= addr_o + 1'b1;
        STEP_ONCE: begin
          addr_o <= addr_o + 1'b1;
          mode_q <= STEP_HOLD;   // single step, then hold
        end
        default:   ;
      endcase
    end
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cmd_method_router.sv
module cmd_method_router
  import cmd_dec_pkg::*;
#(
  parameter int CLS_LIMIT = 'h60,
  parameter int ENG_LIMIT = 'hE00
) (
  input  logic                valid_i,
  input  method_t             meth_i,
  output logic                ready_o,
  output logic                cls_valid_o,
  input  logic                cls_ready_i,
  output logic [ADDR_W+1:0]   cls_offset_o,
  output logic [WORD_W-1:0]   cls_data_o,
  output logic                eng_valid_o,
  input  logic                eng_ready_i,
  output logic [SUBCH_W-1:0]  eng_subch_o,
  output logic [ADDR_W-1:0]   eng_method_o,
  output logic [WORD_W-1:0]   eng_data_o,
  output logic                mac_valid_o,
  input  logic                mac_ready_i,
  output logic [MAC_IDX_W-1:0] mac_index_o,
  output logic                mac_push_o,
  output logic                mac_exec_o,
  output logic [WORD_W-1:0]   mac_data_o
);
  port_e sel;

  always_comb begin
    if (int'(meth_i.addr) < CLS_LIMIT)      sel = PORT_CLS;
    else if (int'(meth_i.addr) < ENG_LIMIT) sel = PORT_ENG;
    else                                    sel = PORT_MAC;
  end

  always_comb begin
    unique case (sel)
      PORT_CLS: ready_o = cls_ready_i;
      PORT_ENG: ready_o = eng_ready_i;
      default:  ready_o = mac_ready_i;
    endcase
  end

  assign cls_valid_o  = valid_i && (sel == PORT_CLS);
  assign cls_offset_o = {meth_i.addr, 2'b00};
  assign cls_data_o   = meth_i.data;

  assign eng_valid_o  = valid_i && (sel == PORT_ENG);
  assign eng_subch_o  = meth_i.subch;
  assign eng_method_o = meth_i.addr;
  assign eng_data_o   = meth_i.data;

  assign mac_valid_o  = valid_i && (sel == PORT_MAC);
  assign mac_index_o  = meth_i.addr[MAC_IDX_W:1];
  assign mac_push_o   = meth_i.addr[0];
  assign mac_exec_o   = mac_valid_o && meth_i.last;
  assign mac_data_o   = meth_i.data;
endmodule

// File: rtl/cmd_method_decoder.sv
module cmd_method_decoder
  import cmd_dec_pkg::*;
#(
  parameter int CLS_LIMIT = 'h60,
  parameter int ENG_LIMIT = 'hE00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 word_valid_i,
  output logic                 word_ready_o,
  output logic                 cls_valid_o,
  input  logic                 cls_ready_i,
  output logic [ADDR_W+1:0]    cls_offset_o,
  output logic [WORD_W-1:0]    cls_data_o,
  output logic                 eng_valid_o,
  input  logic                 eng_ready_i,
  output logic [SUBCH_W-1:0]   eng_subch_o,
  output logic [ADDR_W-1:0]    eng_method_o,
  output logic [WORD_W-1:0]    eng_data_o,
  output logic                 mac_valid_o,
  input  logic                 mac_ready_i,
  output logic [MAC_IDX_W-1:0] mac_index_o,
  output logic                 mac_push_o,
  output logic                 mac_exec_o,
  output logic [WORD_W-1:0]    mac_data_o
);
  logic               h_run, h_imm;
  step_mode_e         h_mode;
  logic [CNT_W-1:0]   h_cnt;
  logic [SUBCH_W-1:0] h_subch;
  logic [ADDR_W-1:0]  h_addr;
  logic [WORD_W-1:0]  h_imm_data;

  logic               busy, last;
  logic [ADDR_W-1:0]  cur_addr;
  logic [SUBCH_W-1:0] cur_subch;

  logic    emit, route_ready, accept;
  method_t meth;

  cmd_hdr_parse u_parse (
    .word_i   (word_i),
    .is_run_o (h_run),
    .is_imm_o (h_imm),
    .mode_o   (h_mode),
    .cnt_o    (h_cnt),
    .subch_o  (h_subch),
    .addr_o   (h_addr),
    .imm_o    (h_imm_data)
  );

  // header words only parse while idle; data words go straight out
  assign emit   = busy || h_imm;
  assign accept = word_valid_i && word_ready_o;
  assign word_ready_o = emit ? route_ready : 1'b1;

  always_comb begin
    if (busy) meth = '{addr: cur_addr, subch: cur_subch, data: word_i, last: last};
    else      meth = '{addr: h_addr, subch: h_subch, data: h_imm_data, last: 1'b1};
  end

  cmd_seq_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept && !busy && h_run),
    .step_i  (accept && busy),
    .cnt_i   (h_cnt),
    .addr_i  (h_addr),
    .subch_i (h_subch),
    .mode_i  (h_mode),
    .busy_o  (busy),
    .last_o  (last),
    .addr_o  (cur_addr),
    .subch_o (cur_subch)
  );

  cmd_method_router #(
    .CLS_LIMIT (CLS_LIMIT),
    .ENG_LIMIT (ENG_LIMIT)
  ) u_router (
    .valid_i      (word_valid_i && emit),
    .meth_i       (meth),
    .ready_o      (route_ready),
    .cls_valid_o  (cls_valid_o),
    .cls_ready_i  (cls_ready_i),
    .cls_offset_o (cls_offset_o),
    .cls_data_o   (cls_data_o),
    .eng_valid_o  (eng_valid_o),
    .eng_ready_i  (eng_ready_i),
    .eng_subch_o  (eng_subch_o),
    .eng_method_o (eng_method_o),
    .eng_data_o   (eng_data_o),
    .mac_valid_o  (mac_valid_o),
    .mac_ready_i  (mac_ready_i),
    .mac_index_o  (mac_index_o),
    .mac_push_o   (mac_push_o),
    .mac_exec_o   (mac_exec_o),
    .mac_data_o   (mac_data_o)
  );
endmodule

// File: rtl/cmd_method_decoder_chk.sv
module cmd_method_decoder_chk #(
  parameter int CLS_LIMIT = 'h60,
  parameter int ENG_LIMIT = 'hE00
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_valid_i,
  input logic        word_ready_o,
  input logic        cls_valid_o,
  input logic        cls_ready_i,
  input logic [13:0] cls_offset_o,
  input logic        eng_valid_o,
  input logic        eng_ready_i,
  input logic [11:0] eng_method_o,
  input logic        mac_valid_o,
  input logic        mac_ready_i
);
  assert_one_port_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cls_valid_o, eng_valid_o, mac_valid_o}));

  assert_quiet_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |-> !(cls_valid_o || eng_valid_o || mac_valid_o));

  assert_stall_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && !word_ready_o) |->
      ((cls_valid_o && !cls_ready_i) || (eng_valid_o && !eng_ready_i) ||
       (mac_valid_o && !mac_ready_i)));

  assert_cls_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_valid_o |-> (cls_offset_o[1:0] == 2'b00 && int'(cls_offset_o) < CLS_LIMIT * 4));

  assert_eng_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o |-> (int'(eng_method_o) >= CLS_LIMIT && int'(eng_method_o) < ENG_LIMIT));
endmodule

bind cmd_method_decoder cmd_method_decoder_chk #(
  .CLS_LIMIT (CLS_LIMIT),
  .ENG_LIMIT (ENG_LIMIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .cls_valid_o  (cls_valid_o),
  .cls_ready_i  (cls_ready_i),
  .cls_offset_o (cls_offset_o),
  .eng_valid_o  (eng_valid_o),
  .eng_ready_i  (eng_ready_i),
  .eng_method_o (eng_method_o),
  .mac_valid_o  (mac_valid_o),
  .mac_ready_i  (mac_ready_i)
);

// File: tb/cmd_method_decoder_tb_top.sv
`timescale 1ns/1ps
module cmd_method_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic        cls_valid_o, cls_ready_i = 1'b1;
  logic [13:0] cls_offset_o;
  logic [31:0] cls_data_o;
  logic        eng_valid_o, eng_ready_i = 1'b1;
  logic [2:0]  eng_subch_o;
  logic [11:0] eng_method_o;
  logic [31:0] eng_data_o;
  logic        mac_valid_o, mac_ready_i = 1'b1;
  logic [6:0]  mac_index_o;
  logic        mac_push_o, mac_exec_o;
  logic [31:0] mac_data_o;

  always #2.5 clk_i = ~clk_i;

  cmd_method_decoder dut_i (.*);

  int n_chk = 0, n_fail = 0, n_seen = 0;
  bit done = 0;
  logic [49:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [49:0] act, input logic [49:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int kind, input int cnt, input int sc, input int addr);
    return {3'(kind), 13'(cnt), 3'(sc), 1'b0, 12'(addr)};
  endfunction

  // expected record: {port[1:0], key[15:0], data[31:0]}
  task automatic expect_m(input string tag, input int addr, input int sc, input logic [31:0] d, input bit last);
    logic [15:0] key;
    logic [1:0]  port;
    if (addr < 'h60) begin
      port = 2'd0; key = 16'(addr * 4);
    end else if (addr < 'hE00) begin
      port = 2'd1; key = {1'b0, 3'(sc), 12'(addr)};
    end else begin
      port = 2'd2; key = {7'd0, 7'((addr >> 1) & 'h7F), 1'(addr & 1), last};
    end
    exp_q.push_back({port, key, d});
    tag_q.push_back(tag);
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk_i);
    word_i = w;
    word_valid_i = 1'b1;
    forever begin
      #1;
      if (word_ready_o) break;
      @(negedge clk_i);
    end
    @(posedge clk_i);
    #1 word_valid_i = 1'b0;
  endtask

  task automatic pop_cmp(input logic [49:0] act);
    n_seen++;
    if (exp_q.size() == 0) chk(1'b0, "unexpected method", act, '0);
    else begin
      logic [49:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(act == e, t, act, e);
    end
  endtask

  // monitor: samples handshakes just before the accepting edge
  initial forever begin
    @(negedge clk_i);
    #2;
    if (rst_ni) begin
      if (cls_valid_o && cls_ready_i) pop_cmp({2'd0, 2'b00, cls_offset_o, cls_data_o});
      if (eng_valid_o && eng_ready_i) pop_cmp({2'd1, 1'b0, eng_subch_o, eng_method_o, eng_data_o});
      if (mac_valid_o && mac_ready_i) pop_cmp({2'd2, 7'd0, mac_index_o, mac_push_o, mac_exec_o, mac_data_o});
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seen0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(word_ready_o && !cls_valid_o && !eng_valid_o && !mac_valid_o, "R1 idle after reset",
        {46'd0, word_ready_o, cls_valid_o, eng_valid_o, mac_valid_o}, 50'b1000);

    // R2 incrementing
    put(hdr(1, 3, 2, 'h100));
    for (int i = 0; i < 3; i++) begin
      expect_m("R2 inc run", 'h100 + i, 2, 32'hA000_0000 + i, i == 2);
      put(32'hA000_0000 + i);
    end
    // R3 non-incrementing
    put(hdr(3, 3, 5, 'h200));
    for (int i = 0; i < 3; i++) begin
      expect_m("R3 hold run", 'h200, 5, 32'hB000_0000 + i, i == 2);
      put(32'hB000_0000 + i);
    end
    // R4 increment-once
    put(hdr(5, 4, 1, 'h300));
    for (int i = 0; i < 4; i++) begin
      expect_m("R4 once run", i == 0 ? 'h300 : 'h301, 1, 32'hC000_0000 + i, i == 3);
      put(32'hC000_0000 + i);
    end
    // R5 immediate, next word still a header
    expect_m("R5 immediate", 'h120, 6, 32'h1ABC, 1);
    put(hdr(4, 'h1ABC, 6, 'h120));
    expect_m("R5 second immediate", 'h121, 6, 32'h0, 1);
    put(hdr(4, 0, 6, 'h121));
    // R7 class edge crossing into engine (R8)
    put(hdr(1, 2, 4, 'h5F));
    expect_m("R7 class top", 'h5F, 4, 32'h11, 0); put(32'h11);
    expect_m("R8 engine bottom", 'h60, 4, 32'h22, 1); put(32'h22);
    expect_m("R7 class zero", 'h0, 0, 32'h5, 1);
    put(hdr(4, 5, 0, 'h0));
    // R8 engine edge crossing into macro (R9)
    put(hdr(1, 2, 3, 'hDFF));
    expect_m("R8 engine top", 'hDFF, 3, 32'h33, 0); put(32'h33);
    expect_m("R9 macro bottom", 'hE00, 3, 32'h44, 1); put(32'h44);
    // R9/R10 macro push run, exec on last only
    put(hdr(3, 3, 0, 'hE21));
    for (int i = 0; i < 3; i++) begin
      expect_m("R10 macro push run", 'hE21, 0, 32'hD0 + i, i == 2);
      put(32'hD0 + i);
    end
    put(hdr(5, 2, 0, 'hE40));
    expect_m("R9 macro start", 'hE40, 0, 32'hE0, 0); put(32'hE0);
    expect_m("R9 macro push", 'hE41, 0, 32'hE1, 1); put(32'hE1);
    expect_m("R10 immediate exec", 'hE02, 0, 32'h5, 1);
    put(hdr(4, 5, 0, 'hE02));
    // R6 ignored headers
    repeat (3) @(negedge clk_i);
    seen0 = n_seen;
    put(hdr(0, 5, 1, 'h100));
    put(hdr(2, 5, 1, 'h100));
    put(hdr(6, 5, 1, 'h100));
    put(hdr(7, 5, 1, 'h100));
    put(hdr(1, 0, 1, 'h100));
    put(hdr(5, 0, 1, 'h100));
    repeat (2) @(negedge clk_i);
    chk(n_seen == seen0, "R6 no output from ignored headers", 50'(n_seen), 50'(seen0));
    expect_m("R6 header after ignored", 'h10, 0, 32'h9, 1);
    put(hdr(4, 9, 0, 'h10));
    // R11 backpressure
    eng_ready_i = 1'b0;
    put(hdr(1, 2, 0, 'h100));
    chk(1'b1, "R11 header accepted while engine stalled", '0, '0);
    expect_m("R11 stalled word", 'h100, 0, 32'h55, 0);
    fork
      put(32'h55);
      begin
        repeat (3) begin
          @(negedge clk_i); #1;
          chk(!word_ready_o, "R11 ready low under stall", 50'(word_ready_o), 50'd0);
        end
        @(negedge clk_i);
        eng_ready_i = 1'b1;
      end
    join
    cls_ready_i = 1'b0;
    expect_m("R11 other port stall ignored", 'h101, 0, 32'h66, 1);
    put(32'h66);
    cls_ready_i = 1'b1;
    // R13 reset mid-run
    put(hdr(1, 3, 0, 'h100));
    expect_m("R13 before reset", 'h100, 0, 32'h77, 0);
    put(32'h77);
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    expect_m("R13 header after reset", 'h10, 0, 32'h77, 1);
    put(hdr(4, 'h77, 0, 'h10));
    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R12 all expected methods seen", 50'(exp_q.size()), 50'd0);
    finish_run();
  end
endmodule